// File: doc/BRIEF.md
# Reseeding Pseudorandom Pattern Source for Hybrid Self-Test

This controller supplies test patterns for a hybrid self-test scheme. A small seed memory holds patterns that were picked to catch faults which random patterns rarely expose. Each seed becomes the starting state of a pattern-generator shift register with linear feedback. The register then runs for a fixed window of pseudorandom patterns, and after that the next seed is fetched.

Two counters are chained. The window counter measures how many patterns have come from the current seed. Each time a window closes, the seed address counter advances. A run ends once every stored seed has had its window. A single start pulse launches a run. The block streams patterns with a valid strobe and raises a done pulse at the end. Response compaction and the unit under test are outside this block.

Top module: `reseed_tpg_ctrl`

## Requirements
- R1: After reset the block is idle: `pat_valid_o` and `done_o` are low and `pattern_o` is zero.
- R2: A `start_i` pulse seen while idle is followed by exactly one cycle with `pat_valid_o` low, in which seed 0 is loaded. The first valid pattern then equals seed 0, which is slice 0 (the least significant W bits) of the `SEEDS` parameter.
- R3: Within a window, each valid pattern p is followed by `{p[W-2:0], ^(p & TAPS)}`, where TAPS defaults to 8'hB8.
- R4: Each window holds exactly WIN_LEN consecutive valid patterns, and the seed itself counts as the first of them.
- R5: Between two windows there is one cycle with `pat_valid_o` low. The next window starts from the seed at the next index, in ascending slice order.
- R6: After the window of the last seed (index NUM_SEEDS-1), `done_o` is high for exactly one cycle, in the cycle right after the last pattern, with `pat_valid_o` low. The block then returns to idle.
- R7: A `start_i` pulse has no effect while a run is in progress, that is during a load cycle, a pattern cycle or the done cycle. No pattern stream follows it.
- R8: `pat_valid_o` and `done_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when the block is idle |
| pat_valid_o | output | 1 | High while `pattern_o` carries a test pattern |
| pattern_o | output | W | Current generator state, used as the test pattern |
| done_o | output | 1 | One-cycle pulse after the final pattern |

## Verification
Two events can fall in the same cycle: the end of the last window, which leads into the done pulse, and a new start request. A start request can also coincide with the done cycle itself. The bench forces a start pulse in the final pattern cycle and in the done cycle, and it also scatters random start pulses over every phase of a run. It then checks that the following cycles stay idle. A correct block keeps the pattern stream identical to the one computed from the seeds alone, and it never restarts.

// File: rtl/reseed_tpg_pkg.sv
package reseed_tpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } ctrl_st_e;
endpackage

// File: rtl/reseed_wrap_cnt.sv
module reseed_wrap_cnt #(
  parameter int unsigned MAX = 4,
  localparam int unsigned CW = (MAX > 1) ? $clog2(MAX) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(MAX - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/reseed_seed_rom.sv
module reseed_seed_rom #(
  parameter int unsigned W  = 8,
  parameter int unsigned NS = 4,
  parameter logic [NS-1:0][W-1:0] SEEDS = '0,
  localparam int unsigned AW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [AW-1:0] addr_i,
  output logic [W-1:0]  seed_o
);
  assign seed_o = SEEDS[addr_i];
endmodule

// File: rtl/reseed_lfsr.sv
module reseed_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q;
  logic         fb;

  assign fb      = ^(st_q & TAPS);
  assign state_o = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= '0;
    else if (load_i)  st_q <= seed_i;
    else if (step_i)  st_q <= {st_q[W-2:0], fb};
  end
endmodule

// File: rtl/reseed_tpg_ctrl.sv
module reseed_tpg_ctrl
  import reseed_tpg_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned WIN_LEN   = 5,
  parameter int unsigned NUM_SEEDS = 4,
  parameter logic [W-1:0] TAPS     = 8'hB8,
  parameter logic [NUM_SEEDS-1:0][W-1:0] SEEDS = {8'h96, 8'h3C, 8'hE1, 8'h01}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic         pat_valid_o,
  output logic [W-1:0] pattern_o,
  output logic         done_o
);
  localparam int unsigned WCW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int unsigned SAW = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1;

  ctrl_st_e       st_q, st_d;
  logic           start_acc, in_run, win_last, seed_last;
  logic [WCW-1:0] win_cnt;
  logic [SAW-1:0] seed_addr;
  logic [W-1:0]   seed_val;

  assign start_acc = start_i && (st_q == ST_IDLE);
  assign in_run    = (st_q == ST_RUN);

  // window length counter
  reseed_wrap_cnt #(.MAX(WIN_LEN)) u_win_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_acc),
    .inc_i  (in_run),
    .cnt_o  (win_cnt),
    .last_o (win_last)
  );

  // seed address counter, cascaded on window wrap
  reseed_wrap_cnt #(.MAX(NUM_SEEDS)) u_seed_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_acc),
    .inc_i  (in_run && win_last),
    .cnt_o  (seed_addr),
    .last_o (seed_last)
  );

  reseed_seed_rom #(.W(W), .NS(NUM_SEEDS), .SEEDS(SEEDS)) u_rom (
    .addr_i (seed_addr),
    .seed_o (seed_val)
  );

  reseed_lfsr #(.W(W), .TAPS(TAPS)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (st_q == ST_LOAD),
    .seed_i  (seed_val),
    .step_i  (in_run),
    .state_o (pattern_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_LOAD;
      ST_LOAD: st_d = ST_RUN;
      ST_RUN:  if (win_last) st_d = seed_last ? ST_FIN : ST_LOAD;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign pat_valid_o = in_run;
  assign done_o      = (st_q == ST_FIN);
endmodule

// File: rtl/reseed_tpg_chk.sv
module reseed_tpg_chk #(
  parameter int unsigned W         = 8,
  parameter int unsigned WIN_LEN   = 5,
  parameter int unsigned NUM_SEEDS = 4,
  parameter logic [W-1:0] TAPS     = 8'hB8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         pat_valid_o,
  input logic [W-1:0] pattern_o,
  input logic         done_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (pat_valid_o) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  // R8
  excl_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pat_valid_o && done_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !pat_valid_o));

  // R3
  lfsr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_valid_o && $past(pat_valid_o)) |->
      (pattern_o == {$past(pattern_o[W-2:0]), ^($past(pattern_o) & TAPS)}));

  // R4
  win_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_valid_o |-> (run_q < 16'(WIN_LEN)));

  // R4
  win_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pat_valid_o) |-> (run_q == 16'(WIN_LEN)));
endmodule

bind reseed_tpg_ctrl reseed_tpg_chk #(
  .W(W), .WIN_LEN(WIN_LEN), .NUM_SEEDS(NUM_SEEDS), .TAPS(TAPS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pat_valid_o (pat_valid_o),
  .pattern_o   (pattern_o),
  .done_o      (done_o)
);

// File: tb/reseed_tpg_ctrl_bench.sv
module reseed_tpg_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int WL = 5;
  localparam int NS = 4;
  localparam logic [W-1:0] TAPS = 8'hB8;
  localparam logic [NS-1:0][W-1:0] SEEDS = {8'h96, 8'h3C, 8'hE1, 8'h01};
  localparam int TOTAL = NS * (WL + 1);

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         pat_valid_o;
  logic [W-1:0] pattern_o;
  logic         done_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  reseed_tpg_ctrl #(
    .W(W), .WIN_LEN(WL), .NUM_SEEDS(NS), .TAPS(TAPS), .SEEDS(SEEDS)
  ) u_reseed_tpg_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .pat_valid_o(pat_valid_o), .pattern_o(pattern_o), .done_o(done_o)
  );

  function automatic logic [W-1:0] step(input logic [W-1:0] p);
    return {p[W-2:0], ^(p & TAPS)};
  endfunction

  function automatic logic [W-1:0] exp_pat(input int seg, input int k);
    logic [W-1:0] p = SEEDS[seg];
    for (int i = 0; i < k; i++) p = step(p);
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  // one run; force_end injects start in the last pattern and done cycles
  task automatic do_run(input bit force_end);
    start_i = 1'b1;
    @(negedge clk_i);
    for (int c = 0; c <= TOTAL + 2; c++) begin
      int seg = c / (WL + 1);
      int off = c % (WL + 1);
      bit inj = ($urandom_range(0, 3) == 0);
      if (force_end && (c == TOTAL - 1 || c == TOTAL)) inj = 1'b1;
      if (c >= TOTAL + 1) inj = 1'b0;
      start_i = inj;
      if (c < TOTAL) begin
        check(done_o == 1'b0, "R8", done_o, 0);
        if (off == 0) begin
          check(pat_valid_o == 1'b0, (seg == 0) ? "R2" : "R5", pat_valid_o, 0);
        end else begin
          check(pat_valid_o == 1'b1, "R4", pat_valid_o, 1);
          check(pattern_o == exp_pat(seg, off - 1),
                (off == 1) ? ((seg == 0) ? "R2" : "R5") : "R3",
                pattern_o, exp_pat(seg, off - 1));
        end
      end else if (c == TOTAL) begin
        check(done_o == 1'b1, "R6", done_o, 1);
        check(pat_valid_o == 1'b0, "R6", pat_valid_o, 0);
      end else begin
        check(done_o == 1'b0, "R7", done_o, 0);
        check(pat_valid_o == 1'b0, "R7", pat_valid_o, 0);
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(pat_valid_o == 1'b0, "R1", pat_valid_o, 0);
    check(done_o == 1'b0, "R1", done_o, 0);
    check(pattern_o == '0, "R1", pattern_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(pat_valid_o == 1'b0 && done_o == 1'b0, "R1", {pat_valid_o, done_o}, 0);

    do_run(1'b1);
    for (int r = 0; r < 12; r++) begin
      int gap = $urandom_range(0, 4);
      for (int g = 0; g < gap; g++) begin
        check(pat_valid_o == 1'b0 && done_o == 1'b0, "R7", {pat_valid_o, done_o}, 0);
        @(negedge clk_i);
      end
      do_run(r[0]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule